// File: doc/BRIEF.md
# Permuted-Order Byte Buffer Copier

This block moves the contents of a 256-entry byte source memory into a 256-entry byte destination memory. It does not walk the positions in ascending order. Each copy step uses an index taken from a keyed bijective scramble of the step count. An observer who sees only the timing of the memory traffic therefore cannot tell which position a given step handles. Four one-byte key values come in with a start pulse. The multiplier key must be odd, because that is what makes the scramble a permutation. The key values come from outside the block, and so do the two memories.

For step n (0 to 255) the index is `((mul * (n ^ xin)) mod 256 + add) mod 256 ^ xout`. The engine issues one source read per cycle. Each read is followed one cycle later by the destination write to the same index. A state machine sequences the run through these states:

- IDLE: waits for start.
- IDLE→RUN: start arrives with an odd multiplier. The keys are latched.
- IDLE→REJECT: start arrives with an even multiplier.
- REJECT→IDLE: the error pulse has been shown.
- RUN: issues the 256 reads.
- RUN→DRAIN: the read for step 255 has been issued.
- DRAIN→FIN: the final write completes.
- FIN→IDLE: the done pulse has been shown.

Top module: `shuffle_copy_engine`

## Requirements
- R1: After reset, and while idle, `busy`, `done`, `err`, `src_rd_en` and `dst_wr_en` are all low.
- R2: For step n, the index is `(((mul*(n^xin)) mod 256) + add) mod 256 ^ xout`. The product is truncated to 8 bits. With mul=1 and the other keys 0, the indices run 0,1,…,255 in order.
- R3: Over one run, each of the 256 indices is written exactly once. Afterwards every destination byte equals the source byte at the same index.
- R4: Start is sampled on clock edge E. The read for step n is issued in the cycle after edge E+n. There are 256 reads on consecutive cycles. The write for each step comes in the next cycle, to the same index, carrying the source read data (read latency is one cycle).
- R5: `done` is high for exactly one cycle, the cycle after the 256th write. With start sampled at edge E, that places the last write 257 cycles after the start cycle and `done` 258 cycles after it.
- R6: A start with an even `key_mul` (bit 0 = 0) raises `err` for exactly the next cycle. It issues no reads and no writes, and the engine stays idle.
- R7: The keys are latched at start. Changing the key inputs during a run does not change the index order.
- R8: A start pulse that arrives while `busy` is high is ignored. The run still makes exactly 256 writes in the original order and raises one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a copy |
| key_mul | input | 8 | Multiplier key; must be odd |
| key_add | input | 8 | Additive offset key |
| key_xout | input | 8 | XOR applied after the add |
| key_xin | input | 8 | XOR applied to the step count |
| busy | output | 1 | High in RUN, DRAIN and FIN |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse on a rejected start |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | 8 | Source read index |
| src_rd_data | input | 8 | Source data, one cycle after the strobe |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_addr | output | 8 | Destination write index |
| dst_wr_data | output | 8 | Destination write data |

## Verification
The assertions assume a source memory that returns data exactly one cycle after each read strobe. They also assume the key inputs matter only in the cycle where start is sampled. The bench's memory model has that fixed latency, and it drives start as a single-cycle pulse.

The bench also changes the keys and re-pulses start in the middle of a run, at points where the requirements say those inputs must be ignored. It then checks the resulting write order against an index sequence it computes from the keys latched at start.

// File: rtl/sce_pkg.sv
package sce_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_FIN,
        ST_REJECT
    } sce_state_e;

    typedef struct packed {
        logic [7:0] mul;
        logic [7:0] add;
        logic [7:0] xout;
        logic [7:0] xin;
    } sce_key_t;

endpackage

// File: rtl/sce_scramble.sv
module sce_scramble #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] mul,
    input  logic [AW-1:0] add,
    input  logic [AW-1:0] xout,
    input  logic [AW-1:0] xin,
    output logic [AW-1:0] idx
);
    localparam int PW = 2 * AW;

    logic [AW-1:0] mixed;
    logic [PW-1:0] prod;
    logic [AW-1:0] shifted;

    always_comb begin
        mixed   = step ^ xin;
        prod    = {{AW{1'b0}}, mul} * {{AW{1'b0}}, mixed};
        shifted = prod[AW-1:0] + add;
        idx     = shifted ^ xout;
    end

endmodule

// File: rtl/sce_ctrl.sv
module sce_ctrl
    import sce_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] in_mul,
    input  logic [AW-1:0] in_add,
    input  logic [AW-1:0] in_xout,
    input  logic [AW-1:0] in_xin,
    output logic [AW-1:0] step,
    output logic [AW-1:0] mul_q,
    output logic [AW-1:0] add_q,
    output logic [AW-1:0] xout_q,
    output logic [AW-1:0] xin_q,
    output logic          rd_en,
    output logic          busy,
    output logic          done,
    output logic          err
);
    localparam logic [AW-1:0] LAST_STEP = '1;

    sce_state_e state, nxt;
    logic       accept;
    logic       last;

    always_comb begin
        accept = start && in_mul[0];
        last   = (step == LAST_STEP);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = accept ? ST_RUN : ST_REJECT;
            end
            ST_RUN:    if (last) nxt = ST_DRAIN;
            ST_DRAIN:  nxt = ST_FIN;
            ST_FIN:    nxt = ST_IDLE;
            ST_REJECT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step   <= '0;
            mul_q  <= '0;
            add_q  <= '0;
            xout_q <= '0;
            xin_q  <= '0;
        end else if (state == ST_IDLE && accept) begin
            step   <= '0;
            mul_q  <= in_mul;
            add_q  <= in_add;
            xout_q <= in_xout;
            xin_q  <= in_xin;
        end else if (state == ST_RUN) begin
            step <= step + 1'b1;
        end
    end

    always_comb begin
        rd_en = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        err   = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_RUN:    begin rd_en = 1'b1; busy = 1'b1; end
            ST_DRAIN:  busy = 1'b1;
            ST_FIN:    begin busy = 1'b1; done = 1'b1; end
            ST_REJECT: err = 1'b1;
            default:   ;
        endcase
    end

    AST_RUN_KEY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> mul_q[0]); // R2

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_RUN) |-> (step - $past(step)) == AW'(1)); // R4

    AST_KEYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mul_q) && $stable(add_q) && $stable(xout_q) && $stable(xin_q))); // R7

    AST_REJECT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(state) == ST_IDLE && $past(start) && !$past(in_mul[0]))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

endmodule

// File: rtl/sce_wrpipe.sv
module sce_wrpipe #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [DW-1:0] wr_data
);
    logic          pend_q;
    logic [AW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            pend_q <= rd_en;
            if (rd_en) idx_q <= rd_idx;
        end
    end

    always_comb begin
        wr_en   = pend_q;
        wr_idx  = idx_q;
        wr_data = rd_data;
    end

endmodule

// File: rtl/shuffle_copy_engine.sv
module shuffle_copy_engine
    import sce_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] key_mul,
    input  logic [AW-1:0] key_add,
    input  logic [AW-1:0] key_xout,
    input  logic [AW-1:0] key_xin,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          src_rd_en,
    output logic [AW-1:0] src_rd_addr,
    input  logic [DW-1:0] src_rd_data,
    output logic          dst_wr_en,
    output logic [AW-1:0] dst_wr_addr,
    output logic [DW-1:0] dst_wr_data
);
    logic [AW-1:0] step;
    logic [AW-1:0] mul_q, add_q, xout_q, xin_q;
    logic          rd_en;

    sce_ctrl #(.AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .in_mul  (key_mul),
        .in_add  (key_add),
        .in_xout (key_xout),
        .in_xin  (key_xin),
        .step    (step),
        .mul_q   (mul_q),
        .add_q   (add_q),
        .xout_q  (xout_q),
        .xin_q   (xin_q),
        .rd_en   (rd_en),
        .busy    (busy),
        .done    (done),
        .err     (err)
    );

    sce_scramble #(.AW(AW)) u_scr (
        .step (step),
        .mul  (mul_q),
        .add  (add_q),
        .xout (xout_q),
        .xin  (xin_q),
        .idx  (src_rd_addr)
    );

    sce_wrpipe #(.AW(AW), .DW(DW)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_idx  (src_rd_addr),
        .rd_data (src_rd_data),
        .wr_en   (dst_wr_en),
        .wr_idx  (dst_wr_addr),
        .wr_data (dst_wr_data)
    );

    assign src_rd_en = rd_en;

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(dst_wr_en) && !dst_wr_en && !src_rd_en)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!src_rd_en && !dst_wr_en && !done)); // R1

    AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_en |-> $past(src_rd_en)); // R4

    AST_ERR_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!src_rd_en && !dst_wr_en && !busy)); // R6

endmodule

// File: tb/shuffle_copy_engine_tb.sv
module shuffle_copy_engine_tb;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] key_mul = '0, key_add = '0, key_xout = '0, key_xin = '0;
    logic          busy, done, err, src_rd_en, dst_wr_en;
    logic [AW-1:0] src_rd_addr, dst_wr_addr;
    logic [7:0]    src_rd_data, dst_wr_data;

    shuffle_copy_engine #(.AW(AW), .DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .key_mul(key_mul), .key_add(key_add), .key_xout(key_xout), .key_xin(key_xin),
        .busy(busy), .done(done), .err(err),
        .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
        .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data)
    );

    logic [7:0] src_mem [DEPTH];
    logic [7:0] dst_mem [DEPTH];
    logic       log_clr = 1'b0;

    always @(posedge clk) begin
        if (src_rd_en) src_rd_data <= src_mem[src_rd_addr];
    end

    always @(posedge clk) begin
        if (log_clr) begin
            for (int k = 0; k < DEPTH; k++) dst_mem[k] <= ~src_mem[k];
        end else if (dst_wr_en) begin
            dst_mem[dst_wr_addr] <= dst_wr_data;
        end
    end

    int         cyc = 0;
    int         rd_n, wr_n, done_n, err_n;
    int         start_cyc, first_rd_cyc, last_wr_cyc, done_cyc, err_cyc;
    bit         start_seen;
    logic [7:0] wr_log [DEPTH];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (log_clr) begin
            rd_n = 0; wr_n = 0; done_n = 0; err_n = 0; start_seen = 0;
            start_cyc = -1; first_rd_cyc = -1; last_wr_cyc = -1; done_cyc = -1; err_cyc = -1;
        end else begin
            if (start && !start_seen) begin start_seen = 1; start_cyc = cyc; end
            if (src_rd_en) begin
                if (rd_n == 0) first_rd_cyc = cyc;
                rd_n++;
            end
            if (dst_wr_en) begin
                if (wr_n < DEPTH) wr_log[wr_n] = dst_wr_addr;
                wr_n++;
                last_wr_cyc = cyc;
            end
            if (done) begin done_n++; done_cyc = cyc; end
            if (err)  begin err_n++;  err_cyc = cyc;  end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_idx(input logic [7:0] x, y, z, w, input int n);
        logic [15:0] p;
        logic [7:0]  nn;
        nn = 8'(n);
        p = 16'(x) * 16'(nn ^ w);
        return 8'(p[7:0] + y) ^ z;
    endfunction

    task automatic prep();
        for (int k = 0; k < DEPTH; k++) src_mem[k] = 8'($urandom);
        @(posedge clk); #1 log_clr = 1'b1;
        @(posedge clk); #1 log_clr = 1'b0;
    endtask

    task automatic pulse_start(input logic [7:0] x, y, z, w);
        @(posedge clk); #1;
        start = 1'b1; key_mul = x; key_add = y; key_xout = z; key_xin = w;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic t_reset();
        check(!busy && !done && !err, "R1", "status low after reset", {busy, done, err}, 0);
        check(!src_rd_en && !dst_wr_en, "R1", "strobes low after reset", {src_rd_en, dst_wr_en}, 0);
    endtask

    // mode 0 plain, 1 keys change mid-run (R7), 2 start re-pulsed while busy (R8)
    task automatic t_copy(input logic [7:0] x, y, z, w, input int mode, input string req);
        int bad_ord, bad_dat, dup;
        int first_bad;
        bit seen [DEPTH];
        prep();
        pulse_start(x, y, z, w);
        if (mode == 1) begin
            repeat (10) @(posedge clk); #1;
            key_mul = 8'($urandom) | 8'h1; key_add = 8'($urandom);
            key_xout = 8'($urandom); key_xin = 8'($urandom);
        end else if (mode == 2) begin
            repeat (40) @(posedge clk);
            pulse_start(8'($urandom) | 8'h1, 8'($urandom), 8'($urandom), 8'($urandom));
        end
        repeat (300) @(posedge clk); #1;

        check(first_rd_cyc == start_cyc + 1, "R4", "first read cycle", first_rd_cyc - start_cyc, 1);
        check(rd_n == DEPTH, "R4", "read count", rd_n, DEPTH);
        check(wr_n == DEPTH, req, "write count", wr_n, DEPTH);
        bad_ord = 0; first_bad = -1;
        for (int k = 0; k < DEPTH; k++) begin
            if (wr_log[k] != ref_idx(x, y, z, w, k)) begin
                if (first_bad < 0) first_bad = k;
                bad_ord++;
            end
        end
        check(bad_ord == 0, (mode == 0) ? "R2" : req, "index order mismatches", bad_ord, 0);
        if (first_bad >= 0)
            check(0, "R2", "first bad index", wr_log[first_bad], ref_idx(x, y, z, w, first_bad));
        dup = 0;
        for (int k = 0; k < DEPTH; k++) seen[k] = 0;
        for (int k = 0; k < DEPTH; k++) begin
            if (seen[wr_log[k]]) dup++;
            seen[wr_log[k]] = 1;
        end
        check(dup == 0, "R3", "repeated indices", dup, 0);
        bad_dat = 0;
        for (int k = 0; k < DEPTH; k++) if (dst_mem[k] != src_mem[k]) bad_dat++;
        check(bad_dat == 0, "R3", "destination bytes differing", bad_dat, 0);
        check(last_wr_cyc == start_cyc + 257, "R4", "last write offset", last_wr_cyc - start_cyc, 257);
        check(done_n == 1, "R5", "done pulses", done_n, 1);
        check(done_cyc == start_cyc + 258, "R5", "done offset", done_cyc - start_cyc, 258);
        check(err_n == 0, "R6", "err on odd key", err_n, 0);
        check(!busy, "R1", "idle after run", busy, 0);
    endtask

    task automatic t_even(input logic [7:0] x);
        int bad_dat;
        prep();
        pulse_start(x, 8'h33, 8'h44, 8'h55);
        repeat (20) @(posedge clk); #1;
        check(err_n == 1, "R6", "err pulses", err_n, 1);
        check(err_cyc == start_cyc + 1, "R6", "err offset", err_cyc - start_cyc, 1);
        check(rd_n == 0 && wr_n == 0, "R6", "traffic on reject", rd_n + wr_n, 0);
        check(done_n == 0, "R6", "done on reject", done_n, 0);
        bad_dat = 0;
        for (int k = 0; k < DEPTH; k++) if (dst_mem[k] != ~src_mem[k]) bad_dat++;
        check(bad_dat == 0, "R6", "destination bytes touched", bad_dat, 0);
        check(!busy, "R6", "busy after reject", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        t_reset();
        t_copy(8'h01, 8'h00, 8'h00, 8'h00, 0, "R2");
        t_copy(8'hFF, 8'h80, 8'h5A, 8'hFF, 0, "R3");
        t_copy(8'h03, 8'hFF, 8'hA5, 8'h0F, 0, "R3");
        for (int r = 0; r < 3; r++)
            t_copy(8'($urandom) | 8'h1, 8'($urandom), 8'($urandom), 8'($urandom), 0, "R3");
        t_even(8'h00);
        t_even(8'hFE);
        t_copy(8'h2B, 8'h11, 8'h77, 8'hC3, 1, "R7");
        t_copy(8'h95, 8'h42, 8'h0D, 8'h60, 2, "R8");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule